// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Port

This block is the configuration front end of a Super I/O function. It has a two-byte window. A byte written at offset 0 selects an index into a 256-entry configuration space. A byte at offset 1 then reads or writes the register at that index. A few indices hold the live setup for the legacy peripherals: one parallel port, up to two serial ports and a floppy controller. The block decodes those registers into one enable bit per device and one I/O base per device. Each base is the stored byte shifted left by a parameterised amount. The peripherals themselves sit outside the block and only consume these outputs.

Every access is one byte wide. The whole window answers only while the `port_en` input from the bridge configuration is high. Within the space, large ranges are read-only and quietly drop writes. Several registers carry write masks that are applied before the byte is stored. Only indices 0xE0 to 0xFF hold state. Every index below 0xE0 reads back as zero. Index 0 is the exception in kind, because it is the index register itself, and a data read there returns 0.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the index is 0. The device ID at 0xE0 reads 0x3C and function select (0xE2) holds 0x0F, so the parallel port is off, both serial ports are on and the floppy is off. The bases are floppy 0x3F0, parallel 0x378, serial 0 0x3F8 and serial 1 0x2F8.
- R2: An enabled write at offset 0 loads the index on the next clock edge. A read at offset 0 returns the current index.
- R3: A read at offset 1 returns 0 while the index is 0, and returns 0 for any index below 0xE0.
- R4: Data writes are dropped for indices 0x00–0xDF, 0xE0, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF. The device ID stays 0x3C.
- R5: Index 0xE2 stores only bits [4:0]. The parallel port is enabled unless bits [1:0] are both 1. Serial port i is enabled by bit i+2, and the floppy controller is enabled by bit 4.
- R6: Index 0xE3 is masked with 0xFC. The floppy base is the stored byte shifted left by BASE_SHIFT (2).
- R7: Index 0xE6 gives the parallel base as the byte shifted left by 2. Indices 0xE7 and 0xE8 are masked with 0xFE and give the serial 0 and serial 1 bases the same way.
- R8: Any other writable index in 0xE0–0xFF (for example 0xEE, 0xF0) stores the written byte unmodified.
- R9: While `port_en` is low, reads at either offset return 0xFF. Writes at either offset change neither the index nor any register.
- R10: Read data is combinational from the current state. A write changes the state and the decoded outputs only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Window enable from the bridge configuration |
| acc_valid | input | 1 | Byte access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 1 | 0 = index byte, 1 = data byte |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for the access presented this cycle |
| par_en | output | 1 | Parallel port enable |
| par_base | output | IO_W | Parallel port I/O base |
| ser_en | output | SER_CNT | Serial port enables, bit i for port i |
| ser_base | output | SER_CNT*IO_W | Serial port bases, port i at bits [i*IO_W +: IO_W] |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | IO_W | Floppy controller I/O base |

## Verification
The bench builds the block with its default parameters: IO_W of 10, BASE_SHIFT of 2 and SER_CNT of 2. With SER_CNT at 2 both serial enables and both serial base registers are live, so the function-select decode and the mask on 0xE8 are observable at the ports. The 10-bit base width makes each masked low bit show up as a fixed zero at a known base bit. That lets the bench see that mask lost and stored byte dropped are two different failures.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   localparam int unsigned CFG_DW = 8;

   // indices whose stored byte feeds the decoded outputs
   localparam logic [7:0] IX_DEVID = 8'hE0;
   localparam logic [7:0] IX_FSEL  = 8'hE2;
   localparam logic [7:0] IX_FDC   = 8'hE3;
   localparam logic [7:0] IX_PAR   = 8'hE6;
   localparam logic [7:0] IX_SER0  = 8'hE7;

   // first index that holds state; everything below reads zero
   localparam logic [7:0] WIN_LO   = 8'hE0;

   typedef enum logic {OFF_INDEX = 1'b0, OFF_DATA = 1'b1} cfg_off_e;

   function automatic logic is_read_only(input logic [7:0] ix);
      logic ro;
      ro = 1'b0;
      if (ix < 8'hE0) ro = 1'b1;
      case (ix)
         8'hE0, 8'hE4, 8'hE5, 8'hF3, 8'hF5, 8'hF7: ro = 1'b1;
         default: ;
      endcase
      if (ix >= 8'hE9 && ix <= 8'hED) ro = 1'b1;
      if (ix >= 8'hF9 && ix <= 8'hFB) ro = 1'b1;
      if (ix >= 8'hFD) ro = 1'b1;
      return ro;
   endfunction

   function automatic logic [7:0] write_mask(input logic [7:0] ix);
      case (ix)
         8'hE2:        return 8'h1F;
         8'hE3:        return 8'hFC;
         8'hE7, 8'hE8: return 8'hFE;
         default:      return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] reset_value(input logic [7:0] ix);
      case (ix)
         8'hE0:   return 8'h3C;
         8'hE2:   return 8'h0F;
         8'hE3:   return 8'hFC;
         8'hE6:   return 8'hDE;
         8'hE7:   return 8'hFE;
         8'hE8:   return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sio_cfg_index.sv
module sio_cfg_index
   import sio_cfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CFG_DW-1:0] load_val,
   output logic [CFG_DW-1:0] idx_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (load) begin
         idx_q <= load_val;
      end
   end

endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
   import sio_cfg_pkg::*;
#(
   parameter logic [7:0] BASE_IX = WIN_LO
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic [CFG_DW-1:0]                 idx,
   input  logic [CFG_DW-1:0]                 wdata,
   output logic [CFG_DW-1:0]                 rd_byte,
   output logic [256-BASE_IX-1:0][CFG_DW-1:0] win_q
);

   localparam int unsigned DEPTH = 256 - BASE_IX;
   localparam int unsigned AW    = $clog2(DEPTH);

   logic [CFG_DW-1:0] rel_ix;
   logic              in_win;

   assign rel_ix = idx - BASE_IX;
   assign in_win = (idx >= BASE_IX);

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      localparam logic [7:0] ADDR = BASE_IX + 8'(k);
      localparam logic       RO   = is_read_only(ADDR);
      localparam logic [7:0] MSK  = write_mask(ADDR);
      localparam logic [7:0] RV   = reset_value(ADDR);

      if (RO) begin : g_const
         assign win_q[k] = RV;
      end else begin : g_store
         logic [CFG_DW-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_q <= RV;
            end else if (wr && idx == ADDR) begin
               ent_q <= wdata & MSK;
            end
         end
         assign win_q[k] = ent_q;
      end
   end

   always_comb begin
      rd_byte = '0;
      if (in_win) begin
         rd_byte = win_q[rel_ix[AW-1:0]];
      end
   end

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
   import sio_cfg_pkg::*;
#(
   parameter int unsigned IO_W       = 10,
   parameter int unsigned BASE_SHIFT = 2,
   parameter int unsigned SER_CNT    = 2,
   parameter logic [7:0]  BASE_IX    = WIN_LO
) (
   input  logic [256-BASE_IX-1:0][CFG_DW-1:0] win_q,
   output logic                              par_en,
   output logic [IO_W-1:0]                   par_base,
   output logic [SER_CNT-1:0]                ser_en,
   output logic [SER_CNT*IO_W-1:0]           ser_base,
   output logic                              fdc_en,
   output logic [IO_W-1:0]                   fdc_base
);

   localparam int unsigned FSEL_SLOT = IX_FSEL - BASE_IX;
   localparam int unsigned FDC_SLOT  = IX_FDC  - BASE_IX;
   localparam int unsigned PAR_SLOT  = IX_PAR  - BASE_IX;
   localparam int unsigned SER_SLOT  = IX_SER0 - BASE_IX;

   logic [CFG_DW-1:0] fsel;
   assign fsel = win_q[FSEL_SLOT];

   // both low select bits set means the parallel port is off
   assign par_en   = ~(&fsel[1:0]);
   assign fdc_en   = fsel[4];
   assign par_base = {win_q[PAR_SLOT], {BASE_SHIFT{1'b0}}};
   assign fdc_base = {win_q[FDC_SLOT], {BASE_SHIFT{1'b0}}};

   for (genvar i = 0; i < SER_CNT; i++) begin : g_ser
      assign ser_en[i] = fsel[i+2];
      assign ser_base[i*IO_W +: IO_W] = {win_q[SER_SLOT+i], {BASE_SHIFT{1'b0}}};
   end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int unsigned IO_W       = 10,
   parameter int unsigned BASE_SHIFT = 2,
   parameter int unsigned SER_CNT    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    port_en,
   input  logic                    acc_valid,
   input  logic                    acc_wr,
   input  logic                    acc_off,
   input  logic [7:0]              acc_wdata,
   output logic [7:0]              acc_rdata,
   output logic                    par_en,
   output logic [IO_W-1:0]         par_base,
   output logic [SER_CNT-1:0]      ser_en,
   output logic [SER_CNT*IO_W-1:0] ser_base,
   output logic                    fdc_en,
   output logic [IO_W-1:0]         fdc_base
);

   localparam int unsigned WIN_DEPTH = 256 - WIN_LO;
   localparam logic [7:0]  RD_IDLE   = 8'hFF;

   if (IO_W != CFG_DW + BASE_SHIFT) begin : g_bad_width
      $error("sio_cfg_port: IO_W must equal 8 + BASE_SHIFT");
   end
   if (SER_CNT < 1 || SER_CNT > 2) begin : g_bad_ser
      $error("sio_cfg_port: SER_CNT must be 1 or 2");
   end

   logic                              acc_go;
   logic                              idx_ld;
   logic                              data_wr;
   logic [CFG_DW-1:0]                 idx_q;
   logic [CFG_DW-1:0]                 win_rd;
   logic [WIN_DEPTH-1:0][CFG_DW-1:0]  win_q;

   assign acc_go  = acc_valid & port_en;
   assign idx_ld  = acc_go & acc_wr & (acc_off == OFF_INDEX);
   assign data_wr = acc_go & acc_wr & (acc_off == OFF_DATA);

   sio_cfg_index u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idx_ld),
      .load_val (acc_wdata),
      .idx_q    (idx_q)
   );

   sio_cfg_regfile #(
      .BASE_IX (WIN_LO)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (data_wr),
      .idx     (idx_q),
      .wdata   (acc_wdata),
      .rd_byte (win_rd),
      .win_q   (win_q)
   );

   sio_cfg_decode #(
      .IO_W       (IO_W),
      .BASE_SHIFT (BASE_SHIFT),
      .SER_CNT    (SER_CNT),
      .BASE_IX    (WIN_LO)
   ) u_dec (
      .win_q    (win_q),
      .par_en   (par_en),
      .par_base (par_base),
      .ser_en   (ser_en),
      .ser_base (ser_base),
      .fdc_en   (fdc_en),
      .fdc_base (fdc_base)
   );

   always_comb begin
      if (!port_en) begin
         acc_rdata = RD_IDLE;
      end else if (acc_off == OFF_INDEX) begin
         acc_rdata = idx_q;
      end else if (idx_q == '0) begin
         acc_rdata = '0;
      end else begin
         acc_rdata = win_rd;
      end
   end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
   parameter int unsigned IO_W       = 10,
   parameter int unsigned BASE_SHIFT = 2,
   parameter int unsigned SER_CNT    = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    port_en,
   input logic                    acc_valid,
   input logic                    acc_wr,
   input logic                    acc_off,
   input logic [7:0]              acc_wdata,
   input logic [7:0]              acc_rdata,
   input logic                    par_en,
   input logic [SER_CNT-1:0]      ser_en,
   input logic [SER_CNT*IO_W-1:0] ser_base,
   input logic                    fdc_en,
   input logic [IO_W-1:0]         fdc_base,
   input logic [7:0]              idx_q
);

   logic fsel_hit;
   assign fsel_hit = acc_valid && port_en && acc_wr && acc_off && (idx_q == 8'hE2);

   // R2
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && port_en && acc_wr && !acc_off) |=> (idx_q == $past(acc_wdata)));

   // R9
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> $stable(idx_q));

   // R9
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> (acc_rdata == 8'hFF));

   // R3
   rd_zero_ix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && acc_off && idx_q == 8'h00) |-> (acc_rdata == 8'h00));

   // R4
   devid_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && acc_off && idx_q == 8'hE0) |-> (acc_rdata == 8'h3C));

   // R5
   en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fsel_hit |=> ($stable(ser_en) && $stable(fdc_en) && $stable(par_en)));

   // R6
   fdc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fdc_base[BASE_SHIFT+1:BASE_SHIFT] == 2'b00);

   // R7
   ser_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_base[BASE_SHIFT] == 1'b0);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
   .IO_W       (IO_W),
   .BASE_SHIFT (BASE_SHIFT),
   .SER_CNT    (SER_CNT)
) u_chk (.*);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

   localparam int CLK_PERIOD = 10;
   localparam int IO_W       = 10;
   localparam int SER_CNT    = 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    port_en = 1'b1;
   logic                    acc_valid = 1'b0;
   logic                    acc_wr = 1'b0;
   logic                    acc_off = 1'b0;
   logic [7:0]              acc_wdata = 8'h00;
   logic [7:0]              acc_rdata;
   logic                    par_en;
   logic [IO_W-1:0]         par_base;
   logic [SER_CNT-1:0]      ser_en;
   logic [SER_CNT*IO_W-1:0] ser_base;
   logic                    fdc_en;
   logic [IO_W-1:0]         fdc_base;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_cfg_port #(.IO_W(IO_W), .BASE_SHIFT(2), .SER_CNT(SER_CNT)) u_sio_cfg_port (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .acc_valid(acc_valid),
      .acc_wr(acc_wr), .acc_off(acc_off), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .par_en(par_en), .par_base(par_base),
      .ser_en(ser_en), .ser_base(ser_base), .fdc_en(fdc_en), .fdc_base(fdc_base)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_byte(input logic off, input logic [7:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_wr = 1'b1; acc_off = off; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic rd_byte(input logic off, output logic [7:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_wr = 1'b0; acc_off = off;
      #1 d = acc_rdata;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic reg_write(input logic [7:0] ix, input logic [7:0] d);
      wr_byte(1'b0, ix);
      wr_byte(1'b1, d);
   endtask

   task automatic reg_read(input logic [7:0] ix, output logic [7:0] d);
      wr_byte(1'b0, ix);
      rd_byte(1'b1, d);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 par_en", 16'(par_en), 16'h0);
      chk("R1 ser_en", 16'(ser_en), 16'h3);
      chk("R1 fdc_en", 16'(fdc_en), 16'h0);
      chk("R1 fdc_base", 16'(fdc_base), 16'h3F0);
      chk("R1 par_base", 16'(par_base), 16'h378);
      chk("R1 ser0_base", 16'(ser_base[IO_W-1:0]), 16'h3F8);
      chk("R1 ser1_base", 16'(ser_base[2*IO_W-1:IO_W]), 16'h2F8);
      rd_byte(1'b0, v);
      chk("R1 index", 16'(v), 16'h00);
      rd_byte(1'b1, v);
      chk("R3 data at index 0", 16'(v), 16'h00);
   endtask

   task automatic t_index();
      logic [7:0] v;
      wr_byte(1'b0, 8'hE0);
      rd_byte(1'b0, v);
      chk("R2 index readback", 16'(v), 16'hE0);
      rd_byte(1'b1, v);
      chk("R1 device id", 16'(v), 16'h3C);
      wr_byte(1'b0, 8'h5A);
      rd_byte(1'b0, v);
      chk("R2 index reload", 16'(v), 16'h5A);
   endtask

   task automatic t_readonly();
      logic [7:0] v;
      reg_write(8'hE0, 8'h55);
      rd_byte(1'b1, v);
      chk("R4 device id kept", 16'(v), 16'h3C);
      reg_write(8'hE4, 8'h77);
      rd_byte(1'b1, v);
      chk("R4 E4 dropped", 16'(v), 16'h00);
      reg_write(8'hFF, 8'h81);
      rd_byte(1'b1, v);
      chk("R4 FF dropped", 16'(v), 16'h00);
      reg_write(8'h40, 8'h12);
      rd_byte(1'b1, v);
      chk("R3 low index reads zero", 16'(v), 16'h00);
      reg_write(8'hF7, 8'h44);
      rd_byte(1'b1, v);
      chk("R4 F7 dropped", 16'(v), 16'h00);
   endtask

   task automatic t_fsel();
      logic [7:0] v;
      reg_write(8'hE2, 8'hFF);
      rd_byte(1'b1, v);
      chk("R5 fsel mask", 16'(v), 16'h1F);
      chk("R5 par off on 11", 16'(par_en), 16'h0);
      chk("R5 fdc on", 16'(fdc_en), 16'h1);
      reg_write(8'hE2, 8'h12);
      chk("R5 par on 10", 16'(par_en), 16'h1);
      chk("R5 ser both off", 16'(ser_en), 16'h0);
      chk("R5 fdc on b4", 16'(fdc_en), 16'h1);
      reg_write(8'hE2, 8'h09);
      chk("R5 ser1 only", 16'(ser_en), 16'h2);
      chk("R5 fdc off", 16'(fdc_en), 16'h0);
      chk("R5 par on 01", 16'(par_en), 16'h1);
   endtask

   task automatic t_bases();
      logic [7:0] v;
      reg_write(8'hE3, 8'h4D);
      rd_byte(1'b1, v);
      chk("R6 fdc mask", 16'(v), 16'h4C);
      chk("R6 fdc base", 16'(fdc_base), 16'h130);
      wr_byte(1'b0, 8'hE6);
      // R10: present the write and look before the capturing edge
      @(negedge clk);
      acc_valid = 1'b1; acc_wr = 1'b1; acc_off = 1'b1; acc_wdata = 8'h5F;
      #1 chk("R10 base before edge", 16'(par_base), 16'h378);
      @(negedge clk);
      acc_valid = 1'b0; acc_wr = 1'b0;
      chk("R7 par base", 16'(par_base), 16'h17C);
      reg_write(8'hE7, 8'h81);
      rd_byte(1'b1, v);
      chk("R7 ser0 mask", 16'(v), 16'h80);
      chk("R7 ser0 base", 16'(ser_base[IO_W-1:0]), 16'h200);
      reg_write(8'hE8, 8'h3B);
      chk("R7 ser1 base", 16'(ser_base[2*IO_W-1:IO_W]), 16'h0E8);
   endtask

   task automatic t_plain();
      logic [7:0] v;
      reg_write(8'hF0, 8'hA5);
      rd_byte(1'b1, v);
      chk("R8 F0 stored", 16'(v), 16'hA5);
      reg_write(8'hEE, 8'h3C);
      rd_byte(1'b1, v);
      chk("R8 EE stored", 16'(v), 16'h3C);
   endtask

   task automatic t_disable();
      logic [7:0] v;
      port_en = 1'b0;
      rd_byte(1'b0, v);
      chk("R9 index read off", 16'(v), 16'hFF);
      rd_byte(1'b1, v);
      chk("R9 data read off", 16'(v), 16'hFF);
      wr_byte(1'b1, 8'h11);
      wr_byte(1'b0, 8'hE6);
      wr_byte(1'b1, 8'h01);
      chk("R9 par base kept", 16'(par_base), 16'h17C);
      port_en = 1'b1;
      rd_byte(1'b0, v);
      chk("R9 index kept", 16'(v), 16'hEE);
      rd_byte(1'b1, v);
      chk("R9 data kept", 16'(v), 16'h3C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index();
      t_readonly();
      t_fsel();
      t_bases();
      t_plain();
      t_disable();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule